// File: doc/BRIEF.md
# Per-Port Receive Statistics Counters

This block keeps a bank of receive statistics for each of a small number of ports. For every frame that ends, the receive path raises a single-cycle event. The event carries a port index, the frame length in bytes including CRC, and six flags: multicast, broadcast, FCS error, alignment error, drop, and interface error. A combinational classifier turns the event into a set of counter hits. The counters of the addressed port then add either one or the frame length, depending on the counter type.

Software reads the counters through a simple register port. The port takes a port index and a counter index and returns the value one cycle later. A global clear-on-read enable selects whether a read zeroes the counter it returned. When an event and a clearing read hit the same counter in the same cycle, the event is counted into the cleared value, so no event is lost. Decoding of the host bus is left to the surrounding logic.

Top module: `rxstat_top`

## Requirements
- R1: Each frame of 64 bytes or more increments exactly one size bucket, selected by its length:
  - bucket 6: exactly 64 bytes;
  - bucket 7: 65–127;
  - bucket 8: 128–255;
  - bucket 9: 256–511;
  - bucket 10: 512–1023;
  - bucket 11: 1024–1518;
  - bucket 12: 1519 up to MAX_FRAME (default 1536).
  
  Frames under 64 bytes or above MAX_FRAME increment no bucket.
- R2: Counter 4 (multicast) counts frames with the multicast flag set and the broadcast flag clear. Counter 5 (broadcast) counts frames with the broadcast flag set and the multicast flag clear.
- R3: Frames under 64 bytes increment counter 14 (runt) when the FCS flag is clear and counter 15 (fragment) when it is set. Frames above MAX_FRAME increment counter 16 (oversize) when the FCS flag is clear and counter 17 (jabber) when it is set.
- R4: Counter 13 counts frames that have the FCS error flag, the alignment error flag, or both set.
- R5: Frames with the drop flag set add one to counter 0 and their length to counter 1. All other frames add one to counter 2 and their length to counter 3.
- R6: The inbound counters are updated as follows:
  - counter 18 counts frames without the interface error flag;
  - counter 19 is 64 bits wide and adds the length of every frame;
  - counter 20 is 16 bits wide and counts frames with the interface error flag.
- R7: A read asserted in cycle N returns, in cycle N+1, the value that the selected port's selected counter held before the cycle-N update. Counter indices 21 to 31 read as zero. Each port's counters change only on events that carry its own port index.
- R8: With the clear enable high, a read zeroes the counter it returns. With the clear enable low, the counter keeps its value.
- R9: An event that hits a counter in the same cycle as a clearing read of that counter leaves the counter equal to that event's increment alone.
- R10: All counters other than 19 and 20 are 32 bits wide. Every counter wraps modulo its width.
- R11: After reset, every counter of every port reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | End-of-frame event strobe |
| ev_port_i | input | PORT_W | Port index of the event |
| ev_len_i | input | LEN_W | Frame length in bytes, CRC included |
| ev_mcast_i | input | 1 | Multicast destination flag |
| ev_bcast_i | input | 1 | Broadcast destination flag |
| ev_fcs_err_i | input | 1 | FCS error flag |
| ev_align_err_i | input | 1 | Alignment error flag |
| ev_drop_i | input | 1 | Frame marked for drop |
| ev_if_err_i | input | 1 | Interface error flag |
| rd_en_i | input | 1 | Read strobe |
| rd_port_i | input | PORT_W | Port index to read |
| rd_cnt_i | input | 5 | Counter index to read |
| rd_clr_en_i | input | 1 | Global clear-on-read enable |
| rd_data_o | output | 64 | Read value, zero-extended, valid the cycle after rd_en_i |

## Verification
The length sweep places frames on both edges of every bucket boundary, and just below 64 and just above MAX_FRAME. This tells a wrong inclusive or exclusive bound apart from a wrong bucket choice.

Flag patterns exercise several combinations:
- multicast alone, broadcast alone, and both flags together, which separates the exclusion rule from a plain flag count;
- FCS and alignment errors on short, long and in-range frames, which splits runt from fragment and oversize from jabber.

Reads are tested with the clear enable both low and high, and one clearing read lands in the same cycle as an event. A long burst of maximum-length frames drives a 32-bit octet counter and the 16-bit error counter past their wrap points, while the 64-bit inbound octet total must not wrap.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int NUM_CNT   = 21;
  localparam int CNT_IDX_W = 5;
  localparam int RD_W      = 64;
  localparam int NUM_BKT   = 7;

  typedef enum logic [CNT_IDX_W-1:0] {
    C_DROP_PKTS = 5'd0,  C_DROP_OCTS = 5'd1,  C_PKTS     = 5'd2,
    C_OCTS      = 5'd3,  C_MCAST     = 5'd4,  C_BCAST    = 5'd5,
    C_B64       = 5'd6,  C_B65       = 5'd7,  C_B128     = 5'd8,
    C_B256      = 5'd9,  C_B512      = 5'd10, C_B1024    = 5'd11,
    C_B1519     = 5'd12, C_FCS_ALIGN = 5'd13, C_RUNT     = 5'd14,
    C_FRAG      = 5'd15, C_OVERSZ    = 5'd16, C_JABBER   = 5'd17,
    C_INB_PKTS  = 5'd18, C_INB_OCTS  = 5'd19, C_INB_ERRS = 5'd20
  } cnt_e;

  function automatic int cnt_width(input int idx);
    if (idx == int'(C_INB_OCTS)) return 64;
    if (idx == int'(C_INB_ERRS)) return 16;
    return 32;
  endfunction

  function automatic bit cnt_is_oct(input int idx);
    return (idx == int'(C_DROP_OCTS)) || (idx == int'(C_OCTS)) ||
           (idx == int'(C_INB_OCTS));
  endfunction

  // bucket lower bounds; upper bound of b is lower bound of b+1 minus one
  function automatic int bkt_lo(input int b);
    case (b)
      0: return 64;
      1: return 65;
      2: return 128;
      3: return 256;
      4: return 512;
      5: return 1024;
      default: return 1519;
    endcase
  endfunction

  typedef struct packed {
    logic mcast;
    logic bcast;
    logic fcs_err;
    logic align_err;
    logic drop;
    logic if_err;
  } ev_flags_t;
endpackage

// File: rtl/rxstat_classify.sv
module rxstat_classify
  import rxstat_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 1536
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [LEN_W-1:0]   len_i,
  input  ev_flags_t          flags_i,
  output logic [NUM_CNT-1:0] hit_o
);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(64);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_FRAME);

  logic [NUM_BKT-1:0] bkt_hit;
  logic short_f, long_f;

  assign short_f = len_i < LEN_MIN;
  assign long_f  = len_i > LEN_MAX;

  for (genvar b = 0; b < NUM_BKT; b++) begin : g_bkt
    localparam logic [LEN_W-1:0] LO = LEN_W'(bkt_lo(b));
    localparam logic [LEN_W-1:0] HI = (b == NUM_BKT-1) ? LEN_MAX
                                                       : LEN_W'(bkt_lo(b+1) - 1);
    assign bkt_hit[b] = (len_i >= LO) && (len_i <= HI);
  end

  always_comb begin
    hit_o = '0;
    if (valid_i) begin
      hit_o[C_DROP_PKTS] = flags_i.drop;
      hit_o[C_DROP_OCTS] = flags_i.drop;
      hit_o[C_PKTS]      = !flags_i.drop;
      hit_o[C_OCTS]      = !flags_i.drop;
      hit_o[C_MCAST]     = flags_i.mcast && !flags_i.bcast;
      hit_o[C_BCAST]     = flags_i.bcast && !flags_i.mcast;
      for (int b = 0; b < NUM_BKT; b++) hit_o[int'(C_B64) + b] = bkt_hit[b];
      hit_o[C_FCS_ALIGN] = flags_i.fcs_err || flags_i.align_err;
      hit_o[C_RUNT]      = short_f && !flags_i.fcs_err;
      hit_o[C_FRAG]      = short_f && flags_i.fcs_err;
      hit_o[C_OVERSZ]    = long_f && !flags_i.fcs_err;
      hit_o[C_JABBER]    = long_f && flags_i.fcs_err;
      hit_o[C_INB_PKTS]  = !flags_i.if_err;
      hit_o[C_INB_OCTS]  = 1'b1;
      hit_o[C_INB_ERRS]  = flags_i.if_err;
    end
  end

  assert_one_bucket_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o[C_B1519:C_B64]));
  assert_bucket_not_runt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_o[C_B1519:C_B64]) |-> !(hit_o[C_RUNT] || hit_o[C_FRAG] ||
                                  hit_o[C_OVERSZ] || hit_o[C_JABBER]));
  assert_cast_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o[C_MCAST] && hit_o[C_BCAST]));
  assert_size_err_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o[C_RUNT], hit_o[C_FRAG], hit_o[C_OVERSZ], hit_o[C_JABBER]}));
endmodule

// File: rtl/rxstat_counter.sv
module rxstat_counter #(
  parameter int WIDTH = 32,
  parameter int STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              clr_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [WIDTH-1:0]  val_o
);
  logic [WIDTH-1:0] add;
  assign add = hit_i ? WIDTH'(step_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_o <= '0;
    else if (clr_i || hit_i) val_o <= (clr_i ? '0 : val_o) + add;
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !clr_i) |=> $stable(val_o));
  assert_clear_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> (val_o == '0));
  assert_clear_keeps_event_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i) |=> (val_o == WIDTH'($past(step_i))));
  assert_modular_add_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !clr_i) |=> (val_o == WIDTH'($past(val_o) + WIDTH'($past(step_i)))));
endmodule

// File: rtl/rxstat_port_bank.sv
module rxstat_port_bank
  import rxstat_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CNT-1:0]           hit_i,
  input  logic [NUM_CNT-1:0]           clr_i,
  input  logic [LEN_W-1:0]             len_i,
  output logic [NUM_CNT-1:0][RD_W-1:0] val_o
);
  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    localparam int W = cnt_width(c);
    localparam bit OCT = cnt_is_oct(c);
    logic [LEN_W-1:0] step;
    logic [W-1:0]     v;

    assign step = OCT ? len_i : LEN_W'(1);

    rxstat_counter #(.WIDTH(W), .STEP_W(LEN_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit_i[c]),
      .clr_i  (clr_i[c]),
      .step_i (step),
      .val_o  (v)
    );
    assign val_o[c] = RD_W'(v);
  end
endmodule

// File: rtl/rxstat_top.sv
module rxstat_top
  import rxstat_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 1536,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ev_valid_i,
  input  logic [PORT_W-1:0]    ev_port_i,
  input  logic [LEN_W-1:0]     ev_len_i,
  input  logic                 ev_mcast_i,
  input  logic                 ev_bcast_i,
  input  logic                 ev_fcs_err_i,
  input  logic                 ev_align_err_i,
  input  logic                 ev_drop_i,
  input  logic                 ev_if_err_i,
  input  logic                 rd_en_i,
  input  logic [PORT_W-1:0]    rd_port_i,
  input  logic [CNT_IDX_W-1:0] rd_cnt_i,
  input  logic                 rd_clr_en_i,
  output logic [RD_W-1:0]      rd_data_o
);
  ev_flags_t                    flags;
  logic [NUM_CNT-1:0]           ev_hit;
  logic [NUM_CNT-1:0]           clr_sel;
  logic [NUM_CNT-1:0]           port_hit [NUM_PORTS];
  logic [NUM_CNT-1:0]           port_clr [NUM_PORTS];
  logic [NUM_CNT-1:0][RD_W-1:0] bank_val [NUM_PORTS];
  logic                         cnt_ok, port_ok;
  logic [RD_W-1:0]              rd_sel;

  assign flags = '{mcast: ev_mcast_i, bcast: ev_bcast_i, fcs_err: ev_fcs_err_i,
                   align_err: ev_align_err_i, drop: ev_drop_i, if_err: ev_if_err_i};

  rxstat_classify #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_cls (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ev_valid_i),
    .len_i   (ev_len_i),
    .flags_i (flags),
    .hit_o   (ev_hit)
  );

  assign cnt_ok  = rd_cnt_i < CNT_IDX_W'(NUM_CNT);
  assign port_ok = {1'b0, rd_port_i} < (PORT_W+1)'(NUM_PORTS);
  assign clr_sel = (rd_en_i && rd_clr_en_i && cnt_ok) ? (NUM_CNT'(1) << rd_cnt_i) : '0;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_hit[p] = (ev_port_i == PORT_W'(p)) ? ev_hit : '0;
    assign port_clr[p] = (rd_port_i == PORT_W'(p)) ? clr_sel : '0;

    rxstat_port_bank #(.LEN_W(LEN_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (port_hit[p]),
      .clr_i  (port_clr[p]),
      .len_i  (ev_len_i),
      .val_o  (bank_val[p])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int c = 0; c < NUM_CNT; c++)
        if (port_ok && cnt_ok && rd_port_i == PORT_W'(p) && rd_cnt_i == CNT_IDX_W'(c))
          rd_sel = bank_val[p][c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_sel;
  end

  assert_bad_index_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !cnt_ok) |=> (rd_data_o == '0));
  assert_read_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  assert_clear_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr_en_i |-> (clr_sel == '0));
endmodule

// File: tb/sim_rxstat_top.sv
module sim_rxstat_top;
  import rxstat_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_port = '0;
  logic [15:0] ev_len = '0;
  logic        ev_m = 1'b0, ev_b = 1'b0, ev_f = 1'b0, ev_a = 1'b0, ev_d = 1'b0, ev_e = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_port = '0;
  logic [4:0]  rd_cnt = '0;
  logic        rd_clr = 1'b0;
  logic [63:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  rxstat_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_valid_i(ev_valid), .ev_port_i(ev_port), .ev_len_i(ev_len),
    .ev_mcast_i(ev_m), .ev_bcast_i(ev_b), .ev_fcs_err_i(ev_f),
    .ev_align_err_i(ev_a), .ev_drop_i(ev_d), .ev_if_err_i(ev_e),
    .rd_en_i(rd_en), .rd_port_i(rd_port), .rd_cnt_i(rd_cnt),
    .rd_clr_en_i(rd_clr), .rd_data_o(rd_data)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic set_ev(input logic [1:0] p, input int len, input logic m, input logic b,
                        input logic f, input logic a, input logic d, input logic e);
    ev_valid = 1'b1; ev_port = p; ev_len = 16'(len);
    ev_m = m; ev_b = b; ev_f = f; ev_a = a; ev_d = d; ev_e = e;
  endtask

  task automatic send(input logic [1:0] p, input int len, input logic m, input logic b,
                      input logic f, input logic a, input logic d, input logic e);
    set_ev(p, len, m, b, f, a, d, e);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, input logic [4:0] c, output logic [63:0] v);
    rd_en = 1'b1; rd_port = p; rd_cnt = c;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic expect_cnt(input string req, input logic [1:0] p, input logic [4:0] c,
                            input logic [63:0] exp);
    logic [63:0] v;
    rd(p, c, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    for (int c = 0; c < NUM_CNT; c++) expect_cnt("R11 reset zero", 2'd0, 5'(c), 64'd0);
    expect_cnt("R11 reset zero port3", 2'd3, C_INB_OCTS, 64'd0);
  endtask

  task automatic t_sizes;
    int lens[15] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 1536, 1537};
    foreach (lens[i]) send(2'd1, lens[i], 0, 0, 0, 0, 0, 0);
    expect_cnt("R1 bucket 64", 2'd1, C_B64, 64'd1);
    expect_cnt("R1 bucket 65-127", 2'd1, C_B65, 64'd2);
    expect_cnt("R1 bucket 128-255", 2'd1, C_B128, 64'd2);
    expect_cnt("R1 bucket 256-511", 2'd1, C_B256, 64'd2);
    expect_cnt("R1 bucket 512-1023", 2'd1, C_B512, 64'd2);
    expect_cnt("R1 bucket 1024-1518", 2'd1, C_B1024, 64'd2);
    expect_cnt("R1 bucket 1519-max", 2'd1, C_B1519, 64'd2);
    expect_cnt("R3 runt", 2'd1, C_RUNT, 64'd1);
    expect_cnt("R3 oversize", 2'd1, C_OVERSZ, 64'd1);
    expect_cnt("R3 no jabber", 2'd1, C_JABBER, 64'd0);
    expect_cnt("R8 no clear on read", 2'd1, C_B65, 64'd2);
  endtask

  task automatic t_cast;
    send(2'd2, 100, 1, 0, 0, 0, 0, 0);
    send(2'd2, 100, 0, 1, 0, 0, 0, 0);
    send(2'd2, 100, 1, 1, 0, 0, 0, 0);
    send(2'd2, 100, 1, 0, 0, 0, 0, 0);
    expect_cnt("R2 multicast", 2'd2, C_MCAST, 64'd2);
    expect_cnt("R2 broadcast", 2'd2, C_BCAST, 64'd1);
  endtask

  task automatic t_errors;
    send(2'd3, 40, 0, 0, 1, 0, 0, 0);
    send(2'd3, 2000, 0, 0, 1, 0, 0, 0);
    send(2'd3, 100, 0, 0, 0, 1, 0, 0);
    send(2'd3, 100, 0, 0, 1, 1, 0, 0);
    expect_cnt("R3 fragment", 2'd3, C_FRAG, 64'd1);
    expect_cnt("R3 jabber", 2'd3, C_JABBER, 64'd1);
    expect_cnt("R3 runt with bad fcs", 2'd3, C_RUNT, 64'd0);
    expect_cnt("R4 fcs or align", 2'd3, C_FCS_ALIGN, 64'd4);
  endtask

  task automatic t_drop_inb;
    send(2'd0, 100, 0, 0, 0, 0, 1, 0);
    send(2'd0, 200, 0, 0, 0, 0, 0, 0);
    send(2'd0, 300, 0, 0, 0, 0, 0, 1);
    expect_cnt("R5 drop pkts", 2'd0, C_DROP_PKTS, 64'd1);
    expect_cnt("R5 drop octs", 2'd0, C_DROP_OCTS, 64'd100);
    expect_cnt("R5 pkts", 2'd0, C_PKTS, 64'd2);
    expect_cnt("R5 octs", 2'd0, C_OCTS, 64'd500);
    expect_cnt("R6 inb pkts", 2'd0, C_INB_PKTS, 64'd2);
    expect_cnt("R6 inb octs", 2'd0, C_INB_OCTS, 64'd600);
    expect_cnt("R6 inb errs", 2'd0, C_INB_ERRS, 64'd1);
    expect_cnt("R7 port isolation", 2'd1, C_PKTS, 64'd15);
    expect_cnt("R7 bad index zero", 2'd0, 5'd25, 64'd0);
  endtask

  task automatic t_clear;
    logic [63:0] v;
    rd_clr = 1'b1;
    expect_cnt("R8 clearing read value", 2'd0, C_PKTS, 64'd2);
    expect_cnt("R8 cleared", 2'd0, C_PKTS, 64'd0);
    send(2'd0, 64, 0, 0, 0, 0, 0, 0);
    set_ev(2'd0, 64, 0, 0, 0, 0, 0, 0);
    rd(2'd0, C_PKTS, v);
    ev_valid = 1'b0;
    check("R9 read returns old value", v, 64'd1);
    expect_cnt("R9 event kept after clear", 2'd0, C_PKTS, 64'd1);
  endtask

  task automatic t_wrap;
    logic [63:0] exp_inb;
    exp_inb = 64'd400 + 64'd65538 * 64'd65535;
    set_ev(2'd2, 65535, 0, 0, 0, 0, 1, 1);
    repeat (65538) @(negedge clk);
    ev_valid = 1'b0;
    expect_cnt("R10 32-bit octet wrap", 2'd2, C_DROP_OCTS, 64'd65534);
    expect_cnt("R10 16-bit error wrap", 2'd2, C_INB_ERRS, 64'd2);
    expect_cnt("R6 64-bit inb octs", 2'd2, C_INB_OCTS, exp_inb);
    expect_cnt("R5 drop pkts burst", 2'd2, C_DROP_PKTS, 64'd65538);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_cast();
    t_errors();
    t_drop_inb();
    t_clear();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule